// File: doc/BRIEF.md
# Redundant Execution Trace Checker

This block sits beside one core of a many-core die. It lets two arbitrary cores check each other's execution without running in lockstep. Every register write the core retires is handed to the block as one event: an 8-bit register address and a 32-bit value. The block folds a run of these events into a short CRC signature. It then either ships the signature to a partner core or compares it with the signature that partner sends back.

A role setting places the core in one of three modes. As the checked core, it sends its signatures out through a valid/ready message port. As the checker core, it queues its own signatures and the incoming partner signatures in two FIFOs and compares their heads in pairs. In non-redundant mode, the block stays out of the way.

The signature width can be 1, 5 or 8 bits, and one signature covers a configurable number of updates. This trades detection latency and coverage against network traffic. A full FIFO stalls the core, and a signature mismatch raises an error exception.

Top module: `trace_checker`

## Requirements
- R1: Each accepted event is treated as one 40-bit word, {address[7:0], value[31:0]}, fed most significant bit first. The CRC register starts at zero at the beginning of every group.
- R2: `cfg_crc_sel` selects the signature width. Value 0 gives CRC-1, which is the even parity of all bits. Value 1 gives CRC-5 with polynomial x^5+x^2+1 (0x05). Values 2 and 3 give CRC-8 with polynomial x^8+x^2+x+1 (0x07). Signatures are zero-extended to 8 bits.
- R3: With interval N (0 is treated as 1), exactly one signature is pushed per N accepted updates. The push happens at the clock edge that accepts the N-th update of the group.
- R4: In the checked role (`cfg_role`=1), the local FIFO head is shown on `tx_valid`/`tx_sig` and is popped when `tx_valid && tx_ready`. In this role `rx_ready` stays low and no error is raised.
- R5: In the checker role (`cfg_role`=2), partner signatures are queued when `rx_valid && rx_ready`, `rx_ready` is high while the partner FIFO is not full, and `tx_valid` stays low.
- R6: A comparison happens only while both FIFOs hold an entry, and it pops both heads in the same cycle. Equal heads raise no error.
- R7: Unequal heads pulse `err_exc` for one cycle, in the cycle after the comparison. The same edge sets `err_sticky`, which stays set until `err_clr` is asserted. A new mismatch wins over a clear.
- R8: While enabled in an active role, `stall` is high whenever a FIFO in use is full, and updates offered during a stall are dropped. `stall` falls in the cycle after an entry leaves.
- R9: When disabled, or when `cfg_role` is 0 or 3, updates are ignored and `stall`, `tx_valid` and `rx_ready` stay low.
- R10: The configuration is sampled only while the block is disabled and is held while it is enabled. Enabling starts with both FIFOs empty and the group counter and CRC at zero.
- R11: After reset, `stall`, `tx_valid`, `rx_ready`, `err_exc` and `err_sticky` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Enables redundancy checking |
| cfg_role | input | 2 | 0 none, 1 checked, 2 checker, 3 none |
| cfg_crc_sel | input | 2 | 0 CRC-1, 1 CRC-5, 2/3 CRC-8 |
| cfg_interval | input | CNT_W | Updates per signature (0 means 1) |
| err_clr | input | 1 | Clears the sticky error flag |
| upd_valid | input | 1 | Register-update event valid |
| upd_addr | input | 8 | Updated register address |
| upd_data | input | 32 | Updated register value |
| stall | output | 1 | Stall request to the core |
| tx_valid | output | 1 | Outgoing signature valid (checked role) |
| tx_sig | output | 8 | Outgoing signature |
| tx_ready | input | 1 | Network accepts the outgoing signature |
| rx_valid | input | 1 | Partner signature valid |
| rx_sig | input | 8 | Partner signature |
| rx_ready | output | 1 | Partner FIFO can accept |
| err_exc | output | 1 | One-cycle redundancy error exception |
| err_sticky | output | 1 | Sticky mismatch flag |

## Verification
The bound assertions watch the cycle-level rules on every clock:
- no stall, no transmit and no receive when idle;
- a full FIFO always stalls, and a stalled update is never taken;
- a mismatch always yields the error pulse and sets the flag;
- a clean comparison never does;
- the flag holds until cleared.

Only the directed scenarios can show that the signature values are the right CRCs for each width and interval, and that groups restart from zero. They also show the FIFO order, that the configuration stays frozen while enabled, and that enabling flushes earlier state.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    ROLE_NONE    = 2'd0,
    ROLE_CHECKED = 2'd1,
    ROLE_CHECKER = 2'd2,
    ROLE_SPARE   = 2'd3
  } role_e;

  localparam int EVT_W = 40;
  localparam int SIG_W = 8;

  // Parity accumulation: CRC-1 with generator x+1
  function automatic logic crc1_word(logic c, logic [EVT_W-1:0] w);
    return c ^ (^w);
  endfunction

  function automatic logic [4:0] crc5_word(logic [4:0] c_in, logic [EVT_W-1:0] w);
    logic [4:0] c;
    logic fb;
    c = c_in;
    for (int i = EVT_W - 1; i >= 0; i--) begin
      fb = c[4] ^ w[i];
      c  = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'h05;
    end
    return c;
  endfunction

  function automatic logic [7:0] crc8_word(logic [7:0] c_in, logic [EVT_W-1:0] w);
    logic [7:0] c;
    logic fb;
    c = c_in;
    for (int i = EVT_W - 1; i >= 0; i--) begin
      fb = c[7] ^ w[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  function automatic logic [SIG_W-1:0] crc_update(logic [1:0] sel, logic [SIG_W-1:0] c,
                                                  logic [EVT_W-1:0] w);
    case (sel)
      2'd0:    return {7'd0, crc1_word(c[0], w)};
      2'd1:    return {3'd0, crc5_word(c[4:0], w)};
      default: return crc8_word(c, w);
    endcase
  endfunction
endpackage

// File: rtl/sig_compressor.sv
module sig_compressor #(
  parameter int CNT_W = 17
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        accept,
  input  logic [7:0]                  addr,
  input  logic [31:0]                 data,
  input  logic [1:0]                  sel,
  input  logic [CNT_W-1:0]            interval,
  output logic                        sig_valid,
  output logic [trace_pkg::SIG_W-1:0] sig
);
  import trace_pkg::*;

  logic [SIG_W-1:0] crc_q, crc_nx;
  logic [CNT_W-1:0] cnt_q, last_idx;

  assign last_idx  = (interval == '0) ? '0 : interval - 1'b1;
  assign crc_nx    = crc_update(sel, crc_q, {addr, data});
  assign sig_valid = accept && (cnt_q == last_idx);
  assign sig       = crc_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      crc_q <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      if (sig_valid) begin
        crc_q <= '0;
        cnt_q <= '0;
      end else begin
        crc_q <= crc_nx;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sig_fifo.sv
module sig_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/trace_checker.sv
module trace_checker #(
  parameter int CNT_W = 17,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [1:0]       cfg_role,
  input  logic [1:0]       cfg_crc_sel,
  input  logic [CNT_W-1:0] cfg_interval,
  input  logic             err_clr,
  input  logic             upd_valid,
  input  logic [7:0]       upd_addr,
  input  logic [31:0]      upd_data,
  output logic             stall,
  output logic             tx_valid,
  output logic [7:0]       tx_sig,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_sig,
  output logic             rx_ready,
  output logic             err_exc,
  output logic             err_sticky
);
  import trace_pkg::*;

  logic             en_q;
  role_e            role_q;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] ivl_q;

  // Named internal events, also used by the bound checker
  logic             is_checked, is_checker, active, flush;
  logic             upd_acc, loc_push, loc_pop, par_push, par_pop;
  logic             loc_full, loc_empty, par_full, par_empty;
  logic             cmp_fire, mismatch;
  logic [SIG_W-1:0] new_sig, loc_head, par_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      role_q <= ROLE_NONE;
      sel_q  <= '0;
      ivl_q  <= '0;
    end else begin
      en_q <= cfg_enable;
      if (!en_q) begin
        role_q <= role_e'(cfg_role);
        sel_q  <= cfg_crc_sel;
        ivl_q  <= cfg_interval;
      end
    end
  end

  assign is_checked = en_q && (role_q == ROLE_CHECKED);
  assign is_checker = en_q && (role_q == ROLE_CHECKER);
  assign active     = is_checked || is_checker;
  assign flush      = !en_q;

  assign stall   = active && (loc_full || (is_checker && par_full));
  assign upd_acc = upd_valid && active && !stall;

  sig_compressor #(.CNT_W(CNT_W)) u_comp (
    .clk(clk), .rst_n(rst_n), .clr(flush), .accept(upd_acc),
    .addr(upd_addr), .data(upd_data), .sel(sel_q), .interval(ivl_q),
    .sig_valid(loc_push), .sig(new_sig)
  );

  assign cmp_fire = is_checker && !loc_empty && !par_empty;
  assign mismatch = cmp_fire && (loc_head != par_head);
  assign loc_pop  = (is_checked && tx_ready && !loc_empty) || cmp_fire;
  assign par_pop  = cmp_fire;
  assign rx_ready = is_checker && !par_full;
  assign par_push = rx_valid && rx_ready;
  assign tx_valid = is_checked && !loc_empty;
  assign tx_sig   = loc_head;

  sig_fifo #(.W(SIG_W), .DEPTH(DEPTH)) u_loc_fifo (
    .clk(clk), .rst_n(rst_n), .clr(flush), .push(loc_push), .din(new_sig),
    .pop(loc_pop), .dout(loc_head), .full(loc_full), .empty(loc_empty)
  );

  sig_fifo #(.W(SIG_W), .DEPTH(DEPTH)) u_par_fifo (
    .clk(clk), .rst_n(rst_n), .clr(flush), .push(par_push), .din(rx_sig),
    .pop(par_pop), .dout(par_head), .full(par_full), .empty(par_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_exc    <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      err_exc    <= mismatch;
      err_sticky <= mismatch || (err_sticky && !err_clr);
    end
  end
endmodule

// File: rtl/trace_checker_sva.sv
module trace_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic is_checked,
  input logic stall,
  input logic tx_valid,
  input logic rx_ready,
  input logic loc_full,
  input logic loc_push,
  input logic loc_pop,
  input logic upd_acc,
  input logic cmp_fire,
  input logic mismatch,
  input logic err_exc,
  input logic err_sticky,
  input logic err_clr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!stall && !tx_valid && !rx_ready));  // R9
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && loc_full) |-> stall);  // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !upd_acc);  // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_full && !loc_pop) |-> !loc_push);  // R8
  AST_ERR_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> (err_exc && err_sticky));  // R7
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !err_clr) |=> err_sticky);  // R7
  AST_MATCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_fire && !mismatch) |=> !err_exc);  // R6
  AST_CHECKED_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_checked && $past(is_checked)) |-> (!err_exc && !rx_ready));  // R4
endmodule

bind trace_checker trace_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .active(active), .is_checked(is_checked),
  .stall(stall), .tx_valid(tx_valid), .rx_ready(rx_ready),
  .loc_full(loc_full), .loc_push(loc_push), .loc_pop(loc_pop),
  .upd_acc(upd_acc), .cmp_fire(cmp_fire), .mismatch(mismatch),
  .err_exc(err_exc), .err_sticky(err_sticky), .err_clr(err_clr)
);

// File: tb/trace_checker_test.sv
module trace_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 17;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0;
  logic [1:0] cfg_role = 2'd0;
  logic [1:0] cfg_crc_sel = 2'd0;
  logic [CNT_W-1:0] cfg_interval = '0;
  logic err_clr = 1'b0;
  logic upd_valid = 1'b0;
  logic [7:0] upd_addr = '0;
  logic [31:0] upd_data = '0;
  logic tx_ready = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_sig = '0;
  logic stall, tx_valid, rx_ready, err_exc, err_sticky;
  logic [7:0] tx_sig;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_checker #(.CNT_W(CNT_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_role(cfg_role),
    .cfg_crc_sel(cfg_crc_sel), .cfg_interval(cfg_interval), .err_clr(err_clr),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_data(upd_data),
    .stall(stall), .tx_valid(tx_valid), .tx_sig(tx_sig), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_sig(rx_sig), .rx_ready(rx_ready),
    .err_exc(err_exc), .err_sticky(err_sticky)
  );

  // Reference signature: shift-register division, width picked by selector
  function automatic logic [7:0] ref_crc(int sel, logic [7:0] start, logic [7:0] a, logic [31:0] d);
    logic [39:0] msg;
    int w;
    int poly;
    int c;
    msg = {a, d};
    if (sel == 0) begin w = 1; poly = 1; end
    else if (sel == 1) begin w = 5; poly = 5; end
    else begin w = 8; poly = 7; end
    c = int'(start);
    for (int k = 0; k < 40; k++) begin
      int topb;
      topb = (c >> (w - 1)) & 1;
      c = (c << 1) & ((1 << w) - 1);
      if ((topb ^ int'(msg[39-k])) != 0) c = c ^ poly;
    end
    return 8'(c);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic configure(int role, int sel, int ivl);
    @(negedge clk);
    cfg_enable = 1'b0;
    cfg_role = 2'(role);
    cfg_crc_sel = 2'(sel);
    cfg_interval = CNT_W'(ivl);
    @(negedge clk);
    cfg_enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_upd(logic [7:0] a, logic [31:0] d);
    upd_valid = 1'b1; upd_addr = a; upd_data = d;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic pop_tx();
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic test_reset();
    chk(!stall && !tx_valid && !rx_ready, "R11 outputs idle", {stall, tx_valid, rx_ready}, 0);
    chk(!err_exc && !err_sticky, "R11 error clear", {err_exc, err_sticky}, 0);
  endtask

  // R1 R2 R4: each width, one update per signature, in FIFO order
  task automatic test_widths();
    for (int s = 0; s < 4; s++) begin
      logic [7:0] e1, e2;
      configure(1, s, 1);
      e1 = ref_crc(s, 8'h00, 8'h05, 32'hDEADBEEF);
      e2 = ref_crc(s, 8'h00, 8'h1F, 32'h00000001);
      send_upd(8'h05, 32'hDEADBEEF);
      send_upd(8'h1F, 32'h00000001);
      chk(tx_valid && tx_sig == e1, "R2 first signature", tx_sig, e1);
      chk(!rx_ready, "R4 checked rx_ready low", rx_ready, 0);
      pop_tx();
      chk(tx_valid && tx_sig == e2, "R1 second signature", tx_sig, e2);
      pop_tx();
      chk(!tx_valid, "R4 drained", tx_valid, 0);
    end
  endtask

  task automatic test_interval();
    logic [7:0] acc;
    configure(1, 2, 10);
    for (int g = 0; g < 2; g++) begin
      acc = 8'h00;
      for (int i = 0; i < 10; i++) begin
        logic [7:0] a;
        logic [31:0] d;
        a = 8'(i + g * 16);
        d = 32'h1234_0000 + 32'(i * 77 + g);
        acc = ref_crc(2, acc, a, d);
        send_upd(a, d);
        if (i == 8) chk(!tx_valid, "R3 no signature before N", tx_valid, 0);
      end
      chk(tx_valid && tx_sig == acc, "R3 group signature", tx_sig, acc);
      pop_tx();
    end
    configure(1, 1, 0);
    send_upd(8'h22, 32'hA5A5A5A5);
    chk(tx_valid && tx_sig == ref_crc(1, 0, 8'h22, 32'hA5A5A5A5), "R3 interval zero acts as one",
        tx_sig, ref_crc(1, 0, 8'h22, 32'hA5A5A5A5));
    pop_tx();
  endtask

  task automatic test_stall();
    int n;
    configure(1, 1, 1);
    for (int i = 0; i < DEPTH; i++) send_upd(8'(i), 32'(i * 3));
    chk(stall, "R8 stall on full", stall, 1);
    send_upd(8'hEE, 32'hFFFF0000);
    chk(stall, "R8 stall held", stall, 1);
    pop_tx();
    chk(!stall, "R8 stall released", stall, 0);
    chk(tx_sig == ref_crc(1, 0, 8'd1, 32'd3), "R8 order kept", tx_sig, ref_crc(1, 0, 8'd1, 32'd3));
    n = 0;
    tx_ready = 1'b1;
    while (tx_valid && n < 40) begin
      n++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk(n == DEPTH - 1, "R8 stalled update dropped", n, DEPTH - 1);
  endtask

  task automatic test_checker();
    logic [7:0] e;
    configure(2, 1, 1);
    e = ref_crc(1, 0, 8'h07, 32'hCAFEF00D);
    rx_valid = 1'b1; rx_sig = e;
    send_upd(8'h07, 32'hCAFEF00D);
    rx_valid = 1'b0;
    chk(!tx_valid, "R5 checker tx quiet", tx_valid, 0);
    @(negedge clk);
    chk(!err_exc && !err_sticky, "R6 match no error", {err_exc, err_sticky}, 0);
    send_upd(8'h08, 32'h1);
    repeat (3) @(negedge clk);
    chk(!err_exc, "R6 no compare with partner empty", err_exc, 0);
    e = ref_crc(1, 0, 8'h08, 32'h1) ^ 8'h01;
    rx_valid = 1'b1; rx_sig = e;
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
    chk(err_exc && err_sticky, "R7 mismatch pulse", {err_exc, err_sticky}, 3);
    @(negedge clk);
    chk(!err_exc && err_sticky, "R7 pulse one cycle, flag held", {err_exc, err_sticky}, 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(!err_sticky, "R7 clear", err_sticky, 0);
    configure(2, 1, 1);
    rx_valid = 1'b1; rx_sig = 8'h11;
    repeat (DEPTH) @(negedge clk);
    rx_valid = 1'b0;
    chk(!rx_ready && stall, "R5 partner full", {rx_ready, stall}, 1);
  endtask

  task automatic test_nonred();
    configure(0, 2, 1);
    for (int i = 0; i < 20; i++) send_upd(8'(i), 32'(i));
    chk(!stall && !tx_valid && !rx_ready, "R9 non-redundant ignores", {stall, tx_valid, rx_ready}, 0);
    configure(3, 2, 1);
    for (int i = 0; i < 20; i++) send_upd(8'(i), 32'(i));
    chk(!stall && !tx_valid, "R9 spare role ignores", {stall, tx_valid}, 0);
    @(negedge clk);
    cfg_enable = 1'b0; cfg_role = 2'd1;
    @(negedge clk);
    send_upd(8'h01, 32'h2);
    @(negedge clk);
    chk(!tx_valid && !stall, "R9 disabled ignores", {tx_valid, stall}, 0);
  endtask

  task automatic test_config();
    configure(1, 2, 1);
    cfg_role = 2'd0;
    cfg_crc_sel = 2'd0;
    send_upd(8'h33, 32'h44);
    chk(tx_valid && tx_sig == ref_crc(2, 0, 8'h33, 32'h44), "R10 config frozen while enabled",
        tx_sig, ref_crc(2, 0, 8'h33, 32'h44));
    cfg_role = 2'd1;
    cfg_enable = 1'b0;
    @(negedge clk);
    cfg_enable = 1'b1;
    @(negedge clk);
    chk(!tx_valid, "R10 enable flushes", tx_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_widths();
    test_interval();
    test_stall();
    test_checker();
    test_nonred();
    test_config();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule